// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

The block holds two 8-bit down-counters, channel 0 and channel 1. Each has a 6-bit prescaler in front of it. Software sets them up through a small byte-wide register port. The port has one mode register and, for each channel, a reload register and a prescaler register. Each channel counts prescaled events down to its terminal count. At that point it either stops or reloads its start value and carries on.

Channel 0 always counts the internal tick strobe. Channel 1 can count the internal tick, or it can use the external timing input in one of four ways:
- as a clock,
- as a gate on the tick,
- as a one-shot trigger,
- as a retriggerable trigger.

Each terminal count gives a one-cycle interrupt strobe. A single timer output pin can show:
- a constant low,
- a level that toggles at channel 0's terminal counts,
- a level that toggles at channel 1's terminal counts,
- the tick strobe itself.

All ports are plain control and status signals. No stream data crosses the block edge, so no valid/ready handshake is involved. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `dual_timer`

## Requirements
- R1: After reset every register is zero, both counters read 0, `tmr_out`, `irq_t0` and `irq_t1` are low, and the mode register reads 0x00.
- R2: Address 1 (channel 0) and address 3 (channel 1) take a start value. Reading them returns the counter's present value, not the last value written. Writing them while a counter holds a value does not change that value. A start value of 0x00 gives 256 counted steps.
- R3: Address 2 (channel 0) and address 4 (channel 1) hold the prescaler. Bits [5:0] divide the counted events by 1 to 63, and 0 divides by 64. The interrupt period is therefore start value times divisor events. These registers read back as 0x00.
- R4: Bit 6 of a prescaler register selects repeat (1) or single pass (0). In repeat mode the counter reloads its start value at each terminal count. In single pass the counter stops at 0, its run bit in the mode register clears, and no further strobe follows.
- R5: The mode register at address 0 has these fields:
  - bit 0: run for channel 0
  - bit 1: run for channel 1
  - bit 2: load for channel 0
  - bit 3: load for channel 1
  - bits [5:4]: output select
  - bits [7:6]: external-input mode

  A load bit copies the start value into the counter and its prescaler. A load and a run bit written together act on the same edge. Load bits read back as 0.
- R6: Bit 7 of the channel 1 prescaler register picks the tick (1) or the external input (0) as channel 1's event source. With the tick selected, activity on `ext_in` has no effect.
- R7: External mode 00: each rising edge of `ext_in` is one event for channel 1.
- R8: External mode 01: a tick counts for channel 1 only while `ext_in` is high.
- R9: External mode 10: a rising edge of `ext_in` loads channel 1 and starts tick counting. Further edges are ignored until terminal count, after which counting pauses until the next edge.
- R10: External mode 11: every rising edge of `ext_in` reloads channel 1 and restarts the count.
- R11: Output select values:
  - 00: `tmr_out` is low.
  - 01: `tmr_out` shows a level that inverts at each channel 0 terminal count.
  - 10: `tmr_out` shows a level that inverts at each channel 1 terminal count.
  - 11: `tmr_out` follows `tick`.
- R12: `irq_t0` and `irq_t1` are high for exactly one cycle per terminal count. They appear in the cycle after the edge that delivered the last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count strobe, one event per high cycle |
| ext_in | input | 1 | External timing input, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tmr_out | output | 1 | Selected timer output |
| irq_t0 | output | 1 | Channel 0 terminal-count strobe |
| irq_t1 | output | 1 | Channel 1 terminal-count strobe |

## Verification
The assertions assume that `ext_in` is already synchronous to `clk`, so a single registered copy is enough to find its rising edges. They also assume that `tick` and `ext_in` change only between clock edges. The stimulus drives every input at the falling edge and draws tick and external-input patterns from a seeded random source. It holds `ext_in` low across each load so that the edge history is known. Programming writes are issued with `tick` held low, so the written channel sees no events at its load edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EXT_CLK    = 2'd0,
    EXT_GATE   = 2'd1,
    EXT_TRIG   = 2'd2,
    EXT_RETRIG = 2'd3
  } ext_mode_e;

  typedef enum logic [1:0] {
    OUT_LOW  = 2'd0,
    OUT_T0   = 2'd1,
    OUT_T1   = 2'd2,
    OUT_TICK = 2'd3
  } out_sel_e;

  localparam int A_MODE  = 0;
  localparam int A_T0CNT = 1;
  localparam int A_T0PRE = 2;
  localparam int A_T1CNT = 3;
  localparam int A_T1PRE = 4;

  localparam int M_RUN0 = 0;
  localparam int M_RUN1 = 1;
  localparam int M_LD0  = 2;
  localparam int M_LD1  = 3;
  localparam int M_OUT  = 4;
  localparam int M_EXT  = 6;

  localparam int P_REP = 6;
  localparam int P_INT = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] div,
  input  logic             src,
  output logic             step
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] pcnt;

  // A divisor of 0 wraps through the full range, giving 2**PRE_W.
  assign step = src && !load && (pcnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)        pcnt <= '0;
    else if (load)     pcnt <= div;
    else if (step)     pcnt <= div;
    else if (src)      pcnt <= pcnt - ONE;
  end

  p_pre_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && !load) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  input  logic             repeat_en,
  input  logic             step,
  output logic [CNT_W-1:0] value,
  output logic             term
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign term = step && !load && (value == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                 value <= '0;
    else if (load)              value <= init;
    else if (term && repeat_en) value <= init;
    else if (step)              value <= value - ONE;
  end

  p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !(term && repeat_en)) |=> (value == $past(value) - ONE));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value == $past(init)));
endmodule

// File: rtl/tmr_t1_source.sv
module tmr_t1_source
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      ext_in,
  input  logic      use_int,
  input  ext_mode_e ext_mode,
  input  logic      run,
  input  logic      cfg_load,
  input  logic      term,
  output logic      src,
  output logic      trig_load
);
  logic ext_q;
  logic armed;
  logic rise;
  logic src_raw;
  logic trig_raw;

  assign rise = ext_in && !ext_q;

  always_comb begin
    src_raw  = 1'b0;
    trig_raw = 1'b0;
    if (use_int) begin
      src_raw = tick;
    end else begin
      unique case (ext_mode)
        EXT_CLK:    src_raw = rise;
        EXT_GATE:   src_raw = tick && ext_in;
        EXT_TRIG: begin
          trig_raw = rise && !armed;
          src_raw  = tick && armed;
        end
        EXT_RETRIG: begin
          trig_raw = rise;
          src_raw  = tick && armed;
        end
        default: ;
      endcase
    end
  end

  assign src       = run && src_raw;
  assign trig_load = run && trig_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      ext_q <= ext_in;
      if (trig_load)             armed <= 1'b1;
      else if (cfg_load || term) armed <= 1'b0;
    end
  end

  p_arm_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(ext_in) && !$past(ext_q)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tmr_out,
  output logic              irq_t0,
  output logic              irq_t1
);
  localparam int NCH = 2;

  logic [NCH-1:0]             run_q;
  logic [NCH-1:0]             rep_q;
  logic [NCH-1:0][PRE_W-1:0]  div_q;
  logic [NCH-1:0][DATA_W-1:0] init_q;
  logic                       t1_int_q;
  ext_mode_e                  ext_mode_q;
  out_sel_e                   out_sel_q;

  logic [NCH-1:0]             ch_src;
  logic [NCH-1:0]             ch_load;
  logic [NCH-1:0]             ch_step;
  logic [NCH-1:0]             ch_term;
  logic [NCH-1:0][DATA_W-1:0] cur;
  logic [NCH-1:0]             irq_q;
  logic [NCH-1:0]             tog_q;
  logic                       mode_wr;
  logic [NCH-1:0]             load_req;
  logic                       trig_load;
  logic                       t1_src;

  assign mode_wr     = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign load_req[0] = mode_wr && wr_data[M_LD0];
  assign load_req[1] = mode_wr && wr_data[M_LD1];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q     <= '0;
      div_q      <= '0;
      rep_q      <= '0;
      t1_int_q   <= 1'b0;
      ext_mode_q <= EXT_CLK;
      out_sel_q  <= OUT_LOW;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_MODE): begin
          out_sel_q  <= out_sel_e'(wr_data[M_OUT +: 2]);
          ext_mode_q <= ext_mode_e'(wr_data[M_EXT +: 2]);
        end
        ADDR_W'(A_T0CNT): init_q[0] <= wr_data;
        ADDR_W'(A_T0PRE): begin
          div_q[0] <= wr_data[PRE_W-1:0];
          rep_q[0] <= wr_data[P_REP];
        end
        ADDR_W'(A_T1CNT): init_q[1] <= wr_data;
        ADDR_W'(A_T1PRE): begin
          div_q[1] <= wr_data[PRE_W-1:0];
          rep_q[1] <= wr_data[P_REP];
          t1_int_q <= wr_data[P_INT];
        end
        default: ;
      endcase
    end
  end

  // Run bits: a mode write wins, otherwise single pass clears at terminal count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (mode_wr) begin
      run_q <= {wr_data[M_RUN1], wr_data[M_RUN0]};
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (ch_term[k] && !rep_q[k]) run_q[k] <= 1'b0;
      end
    end
  end

  tmr_t1_source u_t1src (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ext_in    (ext_in),
    .use_int   (t1_int_q),
    .ext_mode  (ext_mode_q),
    .run       (run_q[1]),
    .cfg_load  (load_req[1]),
    .term      (ch_term[1]),
    .src       (t1_src),
    .trig_load (trig_load)
  );

  assign ch_src[0]  = run_q[0] && tick;
  assign ch_src[1]  = t1_src;
  assign ch_load[0] = load_req[0];
  assign ch_load[1] = load_req[1] || trig_load;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ch_load[i]),
      .div   (div_q[i]),
      .src   (ch_src[i]),
      .step  (ch_step[i])
    );

    tmr_downcount #(.CNT_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ch_load[i]),
      .init      (init_q[i]),
      .repeat_en (rep_q[i]),
      .step      (ch_step[i]),
      .value     (cur[i]),
      .term      (ch_term[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_q[i] <= 1'b0;
        tog_q[i] <= 1'b0;
      end else begin
        irq_q[i] <= ch_term[i];
        tog_q[i] <= tog_q[i] ^ ch_term[i];
      end
    end

    p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_term[i] && !rep_q[i] && !mode_wr) |=> !run_q[i]);

    p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[i] |-> (tog_q[i] != $past(tog_q[i])));
  end

  assign irq_t0 = irq_q[0];
  assign irq_t1 = irq_q[1];

  always_comb begin
    unique case (out_sel_q)
      OUT_LOW:  tmr_out = 1'b0;
      OUT_T0:   tmr_out = tog_q[0];
      OUT_T1:   tmr_out = tog_q[1];
      OUT_TICK: tmr_out = tick;
      default:  tmr_out = 1'b0;
    endcase
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(A_MODE):  rd_data = {ext_mode_q, out_sel_q, 2'b00, run_q};
      ADDR_W'(A_T0CNT): rd_data = cur[0];
      ADDR_W'(A_T1CNT): rd_data = cur[1];
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tmr_out;
  logic       irq_t0;
  logic       irq_t1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_in(ext_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_out(tmr_out), .irq_t0(irq_t0), .irq_t1(irq_t1)
  );

  function automatic int period(int c, int d);
    int cc = (c == 0) ? 256 : c;
    int dd = (d == 0) ? 64 : d;
    return cc * dd;
  endfunction

  function automatic logic [7:0] mk_mode(bit r0, bit r1, bit l0, bit l1,
                                         logic [1:0] osel, logic [1:0] emode);
    return {emode, osel, l1, l0, r1, r0};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    tick = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // kind 0: tick events, 1: rising edges of ext_in, 2: tick gated by ext_in
  task automatic measure(int ch, int kind, bit keep_ext, output int n);
    logic prev;
    bit hit;
    n = 0;
    hit = 1'b0;
    for (int it = 0; it < 4000 && !hit; it++) begin
      prev = ext_in;
      tick = ($urandom % 4) != 0;
      if (!keep_ext) ext_in = $urandom % 2;
      @(posedge clk);
      if (kind == 0 && tick) n++;
      if (kind == 1 && ext_in && !prev) n++;
      if (kind == 2 && tick && ext_in) n++;
      @(negedge clk);
      if ((ch == 0) ? irq_t0 : irq_t1) hit = 1'b1;
    end
    if (!hit) n = -1;
    tick = 1'b0;
  endtask

  task automatic trig_run(int m, output int n);
    n = -1;
    @(negedge clk);
    tick = 1'b1;
    ext_in = 1'b1;
    @(posedge clk);
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (irq_t1) begin
        n = i - 1;
        break;
      end
      ext_in = (i == m) ? 1'b0 : 1'b1;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    int c;
    int d;
    logic o_before;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 reset readback", v, 0);
    end
    chk(!tmr_out && !irq_t0 && !irq_t1, "R1 outputs low",
        {tmr_out, irq_t0, irq_t1}, 0);

    // R2/R5 readback of present value, load and run in one write
    wr(3'd1, 8'd20);
    wr(3'd2, 8'h41);
    wr(3'd0, mk_mode(1, 0, 1, 0, 2'd0, 2'd0));
    rd(3'd0, v);
    chk(v == 8'h01, "R5 load bit reads 0", v, 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); tick = 1'b0;
    rd(3'd1, v);
    chk(v == 8'd15, "R2 present value", v, 15);
    wr(3'd1, 8'd99);
    rd(3'd1, v);
    chk(v == 8'd15, "R2 write keeps present value", v, 15);
    rd(3'd2, v);
    chk(v == 8'h00, "R3 prescaler write-only", v, 0);
    wr(3'd0, 8'h00);

    // R3/R4/R11/R12 random repeat runs on channel 0 with output on T0
    for (int t = 0; t < 6; t++) begin
      c = 1 + ($urandom % 12);
      d = $urandom % 4;
      wr(3'd2, 8'h40 | 8'(d));
      wr(3'd1, 8'(c));
      wr(3'd0, mk_mode(1, 0, 1, 0, 2'd1, 2'd0));
      for (int p = 0; p < 2; p++) begin
        o_before = tmr_out;
        measure(0, 0, 1'b0, n);
        chk(n == period(c, d), "R3 R4 channel 0 period", n, period(c, d));
        chk(tmr_out != o_before, "R11 output toggles on T0", tmr_out, !o_before);
        @(negedge clk);
        chk(!irq_t0, "R12 strobe one cycle", irq_t0, 0);
      end
    end

    // R2 zero start value means 256; R3 zero divisor means 64
    wr(3'd2, 8'h41);
    wr(3'd1, 8'h00);
    wr(3'd0, mk_mode(1, 0, 1, 0, 2'd0, 2'd0));
    measure(0, 0, 1'b0, n);
    chk(n == 256, "R2 start 0 gives 256", n, 256);
    wr(3'd2, 8'h40);
    wr(3'd1, 8'd2);
    wr(3'd0, mk_mode(1, 0, 1, 0, 2'd0, 2'd0));
    measure(0, 0, 1'b0, n);
    chk(n == 128, "R3 divisor 0 gives 64", n, 128);

    // R4 single pass
    wr(3'd2, 8'h01);
    wr(3'd1, 8'd3);
    wr(3'd0, mk_mode(1, 0, 1, 0, 2'd0, 2'd0));
    measure(0, 0, 1'b0, n);
    chk(n == 3, "R4 single pass period", n, 3);
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R4 run bit clears", v[0], 0);
    rd(3'd1, v);
    chk(v == 8'd0, "R4 stops at zero", v, 0);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); if (irq_t0) n++;
    end
    tick = 1'b0;
    chk(n == 0, "R4 no strobe after single pass", n, 0);

    // R6 internal source on channel 1, ext_in toggling randomly
    for (int t = 0; t < 3; t++) begin
      c = 1 + ($urandom % 10);
      d = 1 + ($urandom % 3);
      wr(3'd4, 8'hC0 | 8'(d));
      wr(3'd3, 8'(c));
      wr(3'd0, mk_mode(0, 1, 0, 1, 2'd2, 2'd0));
      o_before = tmr_out;
      measure(1, 0, 1'b0, n);
      chk(n == period(c, d), "R6 internal source ignores ext_in", n, period(c, d));
      chk(tmr_out != o_before, "R11 output toggles on T1", tmr_out, !o_before);
    end

    // R7 external clock
    for (int t = 0; t < 3; t++) begin
      c = 1 + ($urandom % 10);
      d = 1 + ($urandom % 3);
      ext_in = 1'b0;
      wr(3'd4, 8'h40 | 8'(d));
      wr(3'd3, 8'(c));
      wr(3'd0, mk_mode(0, 1, 0, 1, 2'd0, 2'd0));
      measure(1, 1, 1'b0, n);
      chk(n == period(c, d), "R7 external clock edges", n, period(c, d));
    end

    // R8 gate
    for (int t = 0; t < 3; t++) begin
      c = 1 + ($urandom % 10);
      d = 1 + ($urandom % 3);
      ext_in = 1'b0;
      wr(3'd4, 8'h40 | 8'(d));
      wr(3'd3, 8'(c));
      wr(3'd0, mk_mode(0, 1, 0, 1, 2'd0, 2'd1));
      measure(1, 2, 1'b0, n);
      chk(n == period(c, d), "R8 gated ticks", n, period(c, d));
    end

    // R9 one-shot trigger
    ext_in = 1'b0;
    wr(3'd4, 8'h41);
    wr(3'd3, 8'd6);
    wr(3'd0, mk_mode(0, 1, 0, 1, 2'd0, 2'd2));
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
    rd(3'd3, v);
    chk(v == 8'd6 && !irq_t1, "R9 waits for trigger", v, 6);
    trig_run(2, n);
    chk(n == 6, "R9 second edge ignored", n, 6);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); tick = 1'b1;
      if (irq_t1) n++;
    end
    tick = 1'b0;
    chk(n == 0, "R9 pauses after terminal count", n, 0);

    // R10 retriggerable
    ext_in = 1'b0;
    wr(3'd0, mk_mode(0, 1, 0, 1, 2'd0, 2'd3));
    trig_run(2, n);
    chk(n == 9, "R10 edge restarts count", n, 9);
    tick = 1'b0;

    // R11 tick and low selections
    wr(3'd0, mk_mode(0, 0, 0, 0, 2'd3, 2'd0));
    @(negedge clk); tick = 1'b1; #1;
    chk(tmr_out == 1'b1, "R11 follows tick high", tmr_out, 1);
    @(negedge clk); tick = 1'b0; #1;
    chk(tmr_out == 1'b0, "R11 follows tick low", tmr_out, 0);
    wr(3'd0, mk_mode(0, 0, 0, 0, 2'd0, 2'd0));
    @(negedge clk); tick = 1'b1; #1;
    chk(tmr_out == 1'b0, "R11 low selection", tmr_out, 0);
    tick = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule